// File: doc/BRIEF.md
# Dual-Channel Interrupt Gate and DMA Route Select

This block is the small byte-wide register set of a disk interface card. Each drive channel has an interrupt enable and a pending flag. The block combines every channel's enabled request into one interrupt line to the host. Software controls the enable only by the kind of access it makes to the channel's control address. Any write turns the channel's interrupt on. Any read turns it off. A host can therefore mask a channel with a single read and unmask it with a single write of any value.

The two-channel build adds a route-select register. It decides which channel receives the one shared DMA path, and it carries the flag that opens an extended register window. Both builds answer a four-location identification probe, which yields a 4-bit interface type code. The single-channel build (`NUM_CH = 1`) uses different control and status addresses and has no route-select register.

Top module: `irqgate_top`

## Requirements
- R1: After reset every channel's interrupt enable is clear, the route-select state is zero (`dma_sel_o` = 0, `ext_win_o` = 0) and `irq_o` is 0.
- R2: A write strobe on a channel's control address sets that channel's enable whatever the data, from the next clock. Control addresses: channel 0 at 0x2200 and channel 1 at 0x3200 in the two-channel build, channel 0 at 0x0004 in the single-channel build.
- R3: A read strobe (without write) on a channel's control address clears that channel's enable from the next clock, and returns 0x00 in that same cycle.
- R4: A read of a channel's status address returns the sampled pending flag in bit 0 and zero in bits 7..1. Status addresses: 0x2290 for channel 0 and 0x3290 for channel 1 in the two-channel build, 0x0000 in the single-channel build. Neither this read nor any other access away from a channel's control address changes that channel's enable.
- R5: `pend_i` is sampled once per clock. `irq_o` is 1 exactly when some channel has both its enable and its sampled pending flag set, so a pending change reaches `irq_o` one clock later.
- R6: Two-channel build only: a write to address 0x0000 loads the route select. Data bit 0 drives `dma_sel_o` (0 = channel 0, 1 = channel 1) and data bit 5 drives `ext_win_o`, both from the next clock. Writing 0x00 returns both to the reset state. A read of 0x0000 returns those two bits in place, with all other bits 0.
- R7: Reads of 0x2280, 0x2284, 0x2288 and 0x228C return, in bit 0, bits 0, 1, 2 and 3 of the type code, with bits 7..1 zero. The code is 3 for the two-channel build and 15 for the single-channel build.
- R8: When a read and a write strobe hit the same control address in one cycle, the write wins and the enable ends up set.
- R9: Reads of any address not listed above return 0x00, and `rdata_o` is 0x00 whenever `rd_i` is low. Writes to such addresses change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register byte address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one access per clock |
| rd_i | input | 1 | Read strobe, one access per clock |
| rdata_o | output | 8 | Read data, valid in the cycle `rd_i` is high |
| pend_i | input | NUM_CH | Per-channel drive interrupt level |
| irq_o | output | 1 | Combined interrupt request to the host |
| dma_sel_o | output | 1 | Channel that owns the shared DMA path |
| ext_win_o | output | 1 | Extended register window enable |

## Verification
A wrong enable shows up on `irq_o` one clock after the faulty access, but only while that channel's pending input is high. The stimulus therefore keeps pending levels randomly toggling under a stream of control reads and writes, and `irq_o` is compared on every cycle. A pending flag sampled at the wrong time shows up one cycle off, both on `irq_o` and in status read data. A corrupted route-select register shows up on `dma_sel_o`, `ext_win_o` and its read-back from the clock after the write onward. A decode fault shows up as wrong read data at the same access.

// File: rtl/irqgate_pkg.sv
package irqgate_pkg;
  typedef logic [15:0] off_t;

  localparam off_t SEL_OFF = 16'h0000;
  localparam off_t ID_BASE = 16'h2280;
  localparam int   ID_BITS = 4;

  function automatic off_t ctrl_off(int ch, int nch);
    if (nch == 1) return 16'h0004;
    return (ch == 0) ? 16'h2200 : 16'h3200;
  endfunction

  function automatic off_t stat_off(int ch, int nch);
    if (nch == 1) return 16'h0000;
    return (ch == 0) ? 16'h2290 : 16'h3290;
  endfunction

  function automatic logic [ID_BITS-1:0] id_code(int nch);
    return (nch == 1) ? 4'hF : 4'h3;
  endfunction
endpackage

// File: rtl/irqgate_chan.sv
module irqgate_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic pend_i,
  output logic en_o,
  output logic pend_o,
  output logic req_o
);
  logic en_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_i;
      if (set_i)      en_q <= 1'b1;
      else if (clr_i) en_q <= 1'b0;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign req_o  = en_q & pend_q;
endmodule

// File: rtl/irqgate_decode.sv
module irqgate_decode
  import irqgate_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  off_t              addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [NUM_CH-1:0] set_o,
  output logic [NUM_CH-1:0] clr_o,
  output logic [NUM_CH-1:0] stat_hit_o,
  output logic              sel_wr_o,
  output logic              sel_rd_o,
  output logic              id_hit_o,
  output logic [1:0]        id_idx_o
);
  localparam bit HAS_SEL = (NUM_CH == 2);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic ctrl_hit;
    assign ctrl_hit      = (addr_i == ctrl_off(c, NUM_CH));
    assign set_o[c]      = wr_i & ctrl_hit;
    assign clr_o[c]      = rd_i & ~wr_i & ctrl_hit;
    assign stat_hit_o[c] = addr_i == stat_off(c, NUM_CH);
  end

  if (HAS_SEL) begin : g_sel
    assign sel_wr_o = wr_i & (addr_i == SEL_OFF);
    assign sel_rd_o = rd_i & (addr_i == SEL_OFF);
  end else begin : g_nosel
    assign sel_wr_o = 1'b0;
    assign sel_rd_o = 1'b0;
  end

  always_comb begin
    id_hit_o = 1'b0;
    id_idx_o = '0;
    for (int k = 0; k < ID_BITS; k++) begin
      if (addr_i == ID_BASE + off_t'(4 * k)) begin
        id_hit_o = 1'b1;
        id_idx_o = 2'(k);
      end
    end
  end
endmodule

// File: rtl/irqgate_sel.sv
module irqgate_sel #(
  parameter bit PRESENT = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic       dma_sel_o,
  output logic       ext_win_o
);
  if (PRESENT) begin : g_reg
    logic dma_q, win_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dma_q <= 1'b0;
        win_q <= 1'b0;
      end else if (wr_i) begin
        dma_q <= wdata_i[0];
        win_q <= wdata_i[5];
      end
    end
    assign dma_sel_o = dma_q;
    assign ext_win_o = win_q;
  end else begin : g_none
    assign dma_sel_o = 1'b0;
    assign ext_win_o = 1'b0;
  end
endmodule

// File: rtl/irqgate_top.sv
module irqgate_top
  import irqgate_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [7:0]        rdata_o,
  input  logic [NUM_CH-1:0] pend_i,
  output logic              irq_o,
  output logic              dma_sel_o,
  output logic              ext_win_o
);
  localparam logic [ID_BITS-1:0] CODE = id_code(NUM_CH);

  off_t              addr_w;
  logic [NUM_CH-1:0] set_w, clr_w, stat_hit_w, en_w, pq_w, req_w;
  logic              sel_wr_w, sel_rd_w, id_hit_w;
  logic [1:0]        id_idx_w;

  assign addr_w = off_t'(addr_i);

  irqgate_decode #(.NUM_CH(NUM_CH)) i_decode (
    .addr_i    (addr_w),
    .wr_i      (wr_i),
    .rd_i      (rd_i),
    .set_o     (set_w),
    .clr_o     (clr_w),
    .stat_hit_o(stat_hit_w),
    .sel_wr_o  (sel_wr_w),
    .sel_rd_o  (sel_rd_w),
    .id_hit_o  (id_hit_w),
    .id_idx_o  (id_idx_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    irqgate_chan i_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_w[c]),
      .clr_i (clr_w[c]),
      .pend_i(pend_i[c]),
      .en_o  (en_w[c]),
      .pend_o(pq_w[c]),
      .req_o (req_w[c])
    );
  end

  irqgate_sel #(.PRESENT(NUM_CH == 2)) i_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (sel_wr_w),
    .wdata_i  (wdata_i),
    .dma_sel_o(dma_sel_o),
    .ext_win_o(ext_win_o)
  );

  assign irq_o = |req_w;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (sel_rd_w) rdata_o = {2'b00, ext_win_o, 4'b0000, dma_sel_o};
      for (int c = 0; c < NUM_CH; c++)
        if (stat_hit_w[c]) rdata_o = {7'b0, pq_w[c]};
      if (id_hit_w) rdata_o = {7'b0, CODE[id_idx_w]};
    end
  end
endmodule

// File: rtl/irqgate_chk.sv
module irqgate_chk
  import irqgate_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [7:0]        rdata_o,
  input logic [NUM_CH-1:0] pend_i,
  input logic              irq_o,
  input logic              dma_sel_o,
  input logic              ext_win_o,
  input logic [NUM_CH-1:0] en_i
);
  off_t a;
  assign a = off_t'(addr_i);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    a_r2_write_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && a == ctrl_off(c, NUM_CH)) |=> en_i[c]);
    a_r3_read_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && !wr_i && a == ctrl_off(c, NUM_CH)) |=> !en_i[c]);
    a_r4_other_access_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a != ctrl_off(c, NUM_CH)) |=> $stable(en_i[c]));
    a_r4_status_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && a == stat_off(c, NUM_CH)) |-> rdata_o[7:1] == 7'b0);
    a_r5_pending_reaches_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i[c] && pend_i[c] && !(rd_i && !wr_i && a == ctrl_off(c, NUM_CH))) |=> irq_o);
  end

  a_r9_idle_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == 8'h00);

  if (NUM_CH == 2) begin : g_sel
    a_r6_sel_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && a == SEL_OFF) |=> (dma_sel_o == $past(wdata_i[0]) && ext_win_o == $past(wdata_i[5])));
    a_r6_sel_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_i && a == SEL_OFF) |=> ($stable(dma_sel_o) && $stable(ext_win_o)));
  end
endmodule

bind irqgate_top irqgate_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .rdata_o  (rdata_o),
  .pend_i   (pend_i),
  .irq_o    (irq_o),
  .dma_sel_o(dma_sel_o),
  .ext_win_o(ext_win_o),
  .en_i     (en_w)
);

// File: tb/test_irqgate_top.sv
`timescale 1ns/1ps
module test_irqgate_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  pend2 = '0;
  logic        pend1 = 1'b0;
  logic [7:0]  rdata2, rdata1;
  logic        irq2, irq1, dsel2, dsel1, win2, win1;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irqgate_top #(.NUM_CH(2)) i_irqgate_top (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata2), .pend_i(pend2), .irq_o(irq2), .dma_sel_o(dsel2), .ext_win_o(win2));

  irqgate_top #(.NUM_CH(1)) i_irqgate_top_one (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata1), .pend_i(pend1), .irq_o(irq1), .dma_sel_o(dsel1), .ext_win_o(win1));

  // reference state, updated from the requirements
  logic [1:0] m_en2, m_pq2;
  logic       m_en1, m_pq1;
  logic [7:0] m_sel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en2 <= '0; m_pq2 <= '0; m_en1 <= 1'b0; m_pq1 <= 1'b0; m_sel <= '0;
    end else begin
      m_pq2 <= pend2;
      m_pq1 <= pend1;
      if (wr && addr == 14'h2200) m_en2[0] <= 1'b1; else if (rd && addr == 14'h2200) m_en2[0] <= 1'b0;
      if (wr && addr == 14'h3200) m_en2[1] <= 1'b1; else if (rd && addr == 14'h3200) m_en2[1] <= 1'b0;
      if (wr && addr == 14'h0004) m_en1 <= 1'b1; else if (rd && addr == 14'h0004) m_en1 <= 1'b0;
      if (wr && addr == 14'h0000) m_sel <= wdata & 8'h21;
    end
  end

  function automatic logic [7:0] exp_rd2(logic [13:0] a, logic r);
    if (!r) return 8'h00;
    case (a)
      14'h0000: return m_sel;
      14'h2290: return {7'b0, m_pq2[0]};
      14'h3290: return {7'b0, m_pq2[1]};
      14'h2280, 14'h2284: return 8'h01;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd1(logic [13:0] a, logic r);
    if (!r) return 8'h00;
    case (a)
      14'h0000: return {7'b0, m_pq1};
      14'h2280, 14'h2284, 14'h2288, 14'h228C: return 8'h01;
      default:  return 8'h00;
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  // one bus cycle: drive at negedge, compare combinational and state outputs before the edge
  task automatic cyc(logic [13:0] a, logic [7:0] d, logic w, logic r, logic [1:0] p2, logic p1, string req);
    @(negedge clk);
    addr = a; wdata = d; wr = w; rd = r; pend2 = p2; pend1 = p1;
    #1;
    chk({req, " rdata2"}, rdata2, exp_rd2(a, r));
    chk({req, " rdata1"}, rdata1, exp_rd1(a, r));
    chk("R5 irq2", {7'b0, irq2}, {7'b0, |(m_en2 & m_pq2)});
    chk("R5 irq1", {7'b0, irq1}, {7'b0, m_en1 & m_pq1});
    chk("R6 sel2", {6'b0, win2, dsel2}, {6'b0, m_sel[5], m_sel[0]});
    chk("R6 sel1 absent", {6'b0, win1, dsel1}, 8'h00);
  endtask

  task automatic idle(logic [1:0] p2, logic p1);
    cyc(14'h1111, 8'h00, 1'b0, 1'b0, p2, p1, "R9 idle");
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5a17));
    #12 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk); #1;
    chk("R1 irq2", {7'b0, irq2}, 8'h00);
    chk("R1 irq1", {7'b0, irq1}, 8'h00);
    chk("R1 sel", {6'b0, win2, dsel2}, 8'h00);
    // R1: pending alone must not raise irq while disabled
    idle(2'b11, 1'b1); idle(2'b11, 1'b1);
    chk("R1 disabled irq2", {7'b0, irq2}, 8'h00);
    // R2 write enables (any data), R5 latency
    cyc(14'h2200, 8'h00, 1'b1, 1'b0, 2'b01, 1'b0, "R2 ctrl0 wr");
    idle(2'b01, 1'b0);
    chk("R2 irq after enable", {7'b0, irq2}, 8'h01);
    cyc(14'h0004, 8'hA5, 1'b1, 1'b0, 2'b00, 1'b1, "R2 single wr");
    idle(2'b00, 1'b1);
    chk("R2 single irq", {7'b0, irq1}, 8'h01);
    // R4 status reads do not disturb enables
    cyc(14'h2290, 8'h00, 1'b0, 1'b1, 2'b00, 1'b1, "R4 stat0");
    cyc(14'h0000, 8'h00, 1'b0, 1'b1, 2'b00, 1'b1, "R4 single stat");
    cyc(14'h0004, 8'h00, 1'b0, 1'b0, 2'b01, 1'b1, "R4 idle");
    chk("R4 single still enabled", {7'b0, irq1}, 8'h01);
    // R3 read disables, returns zero
    cyc(14'h2200, 8'h00, 1'b0, 1'b1, 2'b01, 1'b1, "R3 ctrl0 rd");
    idle(2'b01, 1'b1);
    chk("R3 irq2 off", {7'b0, irq2}, 8'h00);
    cyc(14'h0004, 8'h00, 1'b0, 1'b1, 2'b01, 1'b1, "R3 single rd");
    idle(2'b01, 1'b1);
    chk("R3 irq1 off", {7'b0, irq1}, 8'h00);
    // R8 read+write same cycle: write wins
    cyc(14'h3200, 8'h00, 1'b1, 1'b1, 2'b10, 1'b0, "R8 rdwr");
    idle(2'b10, 1'b0);
    chk("R8 ch1 enabled", {7'b0, irq2}, 8'h01);
    // R6 route select
    cyc(14'h0000, 8'hFF, 1'b1, 1'b0, 2'b00, 1'b0, "R6 sel wr");
    cyc(14'h0000, 8'h00, 1'b0, 1'b1, 2'b00, 1'b0, "R6 sel rd");
    cyc(14'h0000, 8'h00, 1'b1, 1'b0, 2'b00, 1'b0, "R6 sel clear");
    idle(2'b00, 1'b0);
    chk("R6 sel cleared", {6'b0, win2, dsel2}, 8'h00);
    // R7 identification
    for (int k = 0; k < 4; k++)
      cyc(14'h2280 + 14'(4 * k), 8'h00, 1'b0, 1'b1, 2'b00, 1'b0, "R7 ident");
    // R9 unmapped
    cyc(14'h2281, 8'h00, 1'b0, 1'b1, 2'b00, 1'b0, "R9 unmapped rd");
    cyc(14'h2300, 8'hFF, 1'b1, 1'b0, 2'b00, 1'b0, "R9 unmapped wr");
    // random traffic
    for (int i = 0; i < 2000; i++) begin
      logic [13:0] a;
      case ($urandom % 10)
        0: a = 14'h2200;
        1: a = 14'h3200;
        2: a = 14'h2290;
        3: a = 14'h3290;
        4: a = 14'h0000;
        5: a = 14'h0004;
        6: a = 14'h2280 + 14'(4 * ($urandom % 4));
        default: a = 14'($urandom);
      endcase
      cyc(a, 8'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), "R2-R9 random");
    end
    idle(2'b00, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule